// File: doc/BRIEF.md
# Programmable Interval Timer with Modulo Reload

This block is an 8-bit interval timer for a bus-attached peripheral space. It runs from a 4.194304 MHz system clock, where one machine cycle is four clocks. A prescaler divides that clock down to one of four tick rates: 4096, 16384, 65536 or 262144 Hz. Each tick advances an up-counter by one. When the counter steps past its all-ones value, it does not wrap to zero. Instead it reloads a software-chosen start value from a modulo register and emits a one-clock interrupt request. Software can therefore set the time between interrupts by picking a rate and a modulo value.

A write-only register port selects the register by a 2-bit address. The counter, the modulo value and the control bits are each driven on their own output, so the surrounding logic can read them. The interrupt controller and any free-running divider that software can see live outside this block.

Top module: `tick_timer`

## Requirements
- R1: While reset is low, and after it is released, the counter, the modulo register and the control bits all read zero and the interrupt request is low.
- R2: A write with address 0 loads the counter, address 1 loads the modulo register, and address 2 loads the control bits from data bits [2:0]. The new value appears on the outputs after the write clock edge. A write with address 3 changes no output.
- R3: Control bits [1:0] set the number of clocks per counter increment: code 01 gives 16 clocks, 11 gives 256, 10 gives 64 and 00 gives 1024. At 4.194304 MHz these are 262144, 16384, 65536 and 4096 Hz. The first increment happens exactly that many clocks after the edge that writes the control register.
- R4: While control bit 2 is zero the counter holds its value. The divider is also held at its start, so no partial count builds up.
- R5: A tick that finds the counter at 0xFF loads the counter with the modulo register value instead of wrapping to zero.
- R6: Every overflow raises the interrupt request for exactly one clock, in the clock after the overflow edge. At no other time is it high.
- R7: A counter write on the same edge as a tick wins over both the increment and the reload. If that tick was an overflow, the interrupt request is still raised.
- R8: A modulo write on the same edge as an overflow does not change that reload, which uses the old modulo value. The new modulo value applies from the next overflow on.
- R9: Any write to the control register restarts the divider phase, so the increment timing of R3 counts from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 counter, 1 modulo, 2 control, 3 unused |
| wr_data | input | CNT_W | Write data |
| count_o | output | CNT_W | Current counter value |
| modulo_o | output | CNT_W | Current modulo register value |
| ctrl_o | output | 3 | Control bits: [1:0] rate code, [2] run enable |
| irq_o | output | 1 | One-clock timer interrupt request |

## Verification
Two events can fall on the same clock edge: a software write to the counter or to the modulo register, and a divider tick that increments or reloads the counter. The bench provokes this on purpose. It counts the clocks from a control write and schedules a counter write, or a modulo write, for the exact edge of an 0xFF overflow. It then checks that the written counter value survives with the interrupt still raised, or that the reload takes the old modulo value. A long run of seeded random writes, with a fast rate chosen most of the time, also makes such collisions at many phases. A cycle-by-cycle reference model built from the requirements judges every output after every edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      REG_COUNT  = 2'd0,
      REG_MODULO = 2'd1,
      REG_CTRL   = 2'd2,
      REG_NONE   = 2'd3
   } tmr_reg_e;

   localparam int CTRL_W = 3;
   localparam int RUN_BIT = 2;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int SH0 = 10,
   parameter int SH1 = 4,
   parameter int SH2 = 6,
   parameter int SH3 = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       restart,
   input  logic [1:0] sel,
   output logic       tick
);

   localparam int PRE_W = tmr_pkg::max4(SH0, SH1, SH2, SH3);
   localparam logic [PRE_W-1:0] ONE  = {{(PRE_W-1){1'b0}}, 1'b1};
   localparam logic [PRE_W-1:0] LIM0 = (ONE << SH0) - ONE;
   localparam logic [PRE_W-1:0] LIM1 = (ONE << SH1) - ONE;
   localparam logic [PRE_W-1:0] LIM2 = (ONE << SH2) - ONE;
   localparam logic [PRE_W-1:0] LIM3 = (ONE << SH3) - ONE;

   generate
      if (SH0 < 1 || SH1 < 1 || SH2 < 1 || SH3 < 1) begin : g_bad_shift
         $error("tmr_prescaler: every divide shift must be at least 1");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] lim;

   always_comb begin
      case (sel)
         2'd0:    lim = LIM0;
         2'd1:    lim = LIM1;
         2'd2:    lim = LIM2;
         default: lim = LIM3;
      endcase
   end

   assign tick = run && (pre_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        pre_q <= '0;
      else if (restart || !run || tick)  pre_q <= '0;
      else                               pre_q <= pre_q + ONE;
   end

   // R9
   restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !tick);

   // R3
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic [CNT_W-1:0] mod_q,
   output logic [CNT_W-1:0] count_q,
   output logic             ovf_q
);

   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   logic at_top;
   assign at_top = (count_q == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         ovf_q   <= 1'b0;
      end else begin
         ovf_q <= tick && at_top;
         if (cnt_we)      count_q <= cnt_wdata;
         else if (tick)   count_q <= at_top ? mod_q : count_q + 1'b1;
      end
   end

   // R5
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_we && count_q == TOP) |=> count_q == $past(mod_q));

   // R7
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> count_q == $past(cnt_wdata));

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cnt_we) |=> $stable(count_q));

   // R6
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> !ovf_q);

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
   parameter int CNT_W  = 8,
   parameter int SH_R00 = 10,
   parameter int SH_R01 = 4,
   parameter int SH_R10 = 6,
   parameter int SH_R11 = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] modulo_o,
   output logic [2:0]       ctrl_o,
   output logic             irq_o
);

   import tmr_pkg::*;

   generate
      if (CNT_W < CTRL_W) begin : g_bad_width
         $error("tick_timer: CNT_W must hold the control bits");
      end
   endgenerate

   tmr_reg_e           sel_reg;
   logic               we_cnt, we_mod, we_ctrl;
   logic [CNT_W-1:0]   mod_q;
   logic [CTRL_W-1:0]  ctrl_q;
   logic               tick;
   logic [CNT_W-1:0]   count_q;

   assign sel_reg = tmr_reg_e'(wr_addr);
   assign we_cnt  = wr_en && (sel_reg == REG_COUNT);
   assign we_mod  = wr_en && (sel_reg == REG_MODULO);
   assign we_ctrl = wr_en && (sel_reg == REG_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_q  <= '0;
         ctrl_q <= '0;
      end else begin
         if (we_mod)  mod_q  <= wr_data;
         if (we_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];
      end
   end

   tmr_prescaler #(
      .SH0(SH_R00), .SH1(SH_R01), .SH2(SH_R10), .SH3(SH_R11)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl_q[RUN_BIT]),
      .restart (we_ctrl),
      .sel     (ctrl_q[1:0]),
      .tick    (tick)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .cnt_we    (we_cnt),
      .cnt_wdata (wr_data),
      .mod_q     (mod_q),
      .count_q   (count_q),
      .ovf_q     (irq_o)
   );

   assign count_o  = count_q;
   assign modulo_o = mod_q;
   assign ctrl_o   = ctrl_q;

   // R4
   stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[RUN_BIT] |-> !tick);

   // R6
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(count_q) == {CNT_W{1'b1}});

   // R2
   unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_reg == REG_NONE) |=> ($stable(mod_q) && $stable(ctrl_q)));

endmodule

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] count_o, modulo_o;
   logic [2:0] ctrl_o;
   logic       irq_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tick_timer dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .count_o(count_o), .modulo_o(modulo_o),
      .ctrl_o(ctrl_o), .irq_o(irq_o)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int clocks_per_step(input logic [1:0] code);
      case (code)
         2'd0:    return 1024;
         2'd1:    return 16;
         2'd2:    return 64;
         default: return 256;
      endcase
   endfunction

   // reference model, built from the requirements
   logic [7:0] m_cnt = 0, m_mod = 0;
   logic [2:0] m_ctrl = 0;
   logic       m_irq = 0;
   int         m_pre = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_mod = 0; m_ctrl = 0; m_irq = 0; m_pre = 0;
      end else begin
         bit tk;
         logic [7:0] nc;
         tk = m_ctrl[2] && (m_pre == clocks_per_step(m_ctrl[1:0]) - 1);
         m_irq = tk && (m_cnt == 8'hFF);
         nc = m_cnt;
         if (tk) nc = (m_cnt == 8'hFF) ? m_mod : m_cnt + 8'd1;
         if (wr_en && wr_addr == 2'd0) nc = wr_data;
         m_cnt = nc;
         if (wr_en && wr_addr == 2'd2) m_pre = 0;
         else if (!m_ctrl[2] || tk)    m_pre = 0;
         else                          m_pre = m_pre + 1;
         if (wr_en && wr_addr == 2'd1) m_mod = wr_data;
         if (wr_en && wr_addr == 2'd2) m_ctrl = wr_data[2:0];
      end
      #1;
      if (rst_n && !done) begin
         check("model count R3 R5 R7", count_o, m_cnt);
         check("model modulo R2 R8", modulo_o, m_mod);
         check("model control R2 R9", ctrl_o, m_ctrl);
         check("model irq R6", irq_o, m_irq);
      end
   end

   // drive between edges; returns 1 ns after the write edge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      #1;
      // R1 values during reset
      check("R1 count in reset", count_o, 0);
      check("R1 irq in reset", irq_o, 0);
      rst_n = 1'b1;
      idle(2);
      check("R1 count", count_o, 0);
      check("R1 modulo", modulo_o, 0);
      check("R1 control", ctrl_o, 0);

      // R3 rate code 10 = 64 clocks per step
      wr(2'd0, 8'h10);
      wr(2'd2, 8'b110);
      idle(63);
      check("R3 before 64 clocks", count_o, 8'h10);
      idle(1);
      check("R3 at 64 clocks", count_o, 8'h11);

      // R9 control rewrite restarts phase
      idle(30);
      wr(2'd2, 8'b110);
      idle(63);
      check("R9 no step before restarted period", count_o, 8'h11);
      idle(1);
      check("R9 step after restarted period", count_o, 8'h12);

      // R4 stop
      wr(2'd2, 8'b010);
      idle(2000);
      check("R4 stopped counter holds", count_o, 8'h12);
      // R2 unused address
      wr(2'd3, 8'hFF);
      check("R2 addr3 count", count_o, 8'h12);
      check("R2 addr3 modulo", modulo_o, 0);
      check("R2 addr3 control", ctrl_o, 3'b010);

      // R5 R6 reload at code 01 (16 clocks)
      wr(2'd1, 8'hF0);
      wr(2'd0, 8'hFF);
      wr(2'd2, 8'b101);
      idle(15);
      check("R5 before overflow", count_o, 8'hFF);
      check("R6 irq low before", irq_o, 0);
      idle(1);
      check("R5 reload", count_o, 8'hF0);
      check("R6 irq pulse", irq_o, 1);
      idle(1);
      check("R6 irq one clock", irq_o, 0);

      // R7 counter write on overflow edge
      wr(2'd1, 8'h40);
      wr(2'd0, 8'hFF);
      wr(2'd2, 8'b101);
      idle(14);
      @(posedge clk); #1;
      wr(2'd0, 8'h33);
      check("R7 write wins", count_o, 8'h33);
      check("R7 irq still raised", irq_o, 1);

      // R8 modulo write on overflow edge
      wr(2'd1, 8'h20);
      wr(2'd0, 8'hFF);
      wr(2'd2, 8'b101);
      idle(14);
      @(posedge clk); #1;
      wr(2'd1, 8'h77);
      check("R8 old modulo reloaded", count_o, 8'h20);
      check("R8 new modulo kept", modulo_o, 8'h77);
      check("R8 irq", irq_o, 1);

      // random phase
      for (int i = 0; i < 20000; i++) begin
         if ($urandom % 5 == 0) begin
            logic [1:0] a;
            logic [7:0] d;
            a = 2'($urandom % 4);
            d = 8'($urandom);
            if (a == 2'd2 && ($urandom % 4 != 0)) d[2:0] = 3'b101;
            if (a == 2'd0 && ($urandom % 3 == 0)) d = 8'hFE;
            wr(a, d);
         end else begin
            idle(1);
         end
      end
      finish_run();
   end

endmodule